// File: doc/BRIEF.md
# Change-Detect Sensor Interrupt Controller

This block watches an eight-bit sensor bus, registers it on every clock, and raises an interrupt request whenever the newly registered value differs from the sample taken one clock earlier. The request stays raised until the processor answers with an interrupt-acknowledge pulse. Each change event therefore produces exactly one interrupt, unless a further change arrives in the same cycle as the acknowledge.

Software reads the most recent sample through a single-register read port. That port uses the common cycle/strobe/acknowledge handshake. The acknowledge follows the cycle and strobe inputs in the same clock. The port never applies back-pressure, so every access completes in the clock it is presented.

Top module: `sensirq_ctrl`

## Requirements
- R1: While `rst_i` is high on a rising edge, both sample registers and the pending request are cleared, so `int_req` reads 0 and an access reads `dat_o` = 0x00 after that edge.
- R2: During an access (`cyc_i` and `stb_i` both 1), `dat_o` equals the sensor value captured at the most recent rising edge.
- R3: When the sensor value changes, `int_req` becomes 1 after the second rising edge that follows the change (one edge to sample, one to latch the request). A difference in any single bit counts as a change.
- R4: Once raised, `int_req` stays 1 on every following edge at which `int_ack` is 0.
- R5: An edge with `int_ack` = 1 and no newly detected change drops `int_req` to 0.
- R6: If a newly detected change and `int_ack` = 1 meet on the same edge, `int_req` stays 1.
- R7: A sensor value that stays constant raises no request, and `int_ack` has no effect while nothing is pending.
- R8: The first sample taken after reset loads both sample registers, so a nonzero sensor value present at reset release raises no interrupt.
- R9: `ack_o` is 1 exactly when `cyc_i` and `stb_i` are both 1, in the same cycle. Outside an access, `dat_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Bus strobe for this controller |
| ack_o | output | 1 | Access acknowledge, same cycle |
| dat_o | output | 8 | Latest sensor sample during an access, else zero |
| sense_i | input | 8 | Raw sensor value |
| int_req | output | 1 | Pending change interrupt |
| int_ack | input | 1 | Processor acknowledge of the interrupt |

## Verification
The main stimulus is a cycle-by-cycle sequence of sensor values and acknowledge pulses. It covers a multi-bit jump, a single-bit change, a full inversion and a back-to-back pair of changes. These patterns separate a comparator that sees every bit from one that misses some, and a request that holds from one that self-clears. Acknowledges are placed both on quiet edges and on edges that coincide with a fresh change, which tells a correct priority of set over clear apart from the reverse. Directed runs hold a nonzero sensor value across reset release, to expose a spurious first interrupt, and reset the block while a request is pending.

// File: rtl/sensirq_pkg.sv
package sensirq_pkg;
  parameter int DATA_W = 8;
  typedef logic [DATA_W-1:0] sample_t;
endpackage

// File: rtl/sensirq_sampler.sv
module sensirq_sampler #(
  parameter int W = sensirq_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic         primed_o
);
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (!primed_q) begin
      // first capture fills both stages so no false difference appears
      cur_q    <= raw_i;
      prev_q   <= raw_i;
      primed_q <= 1'b1;
    end else begin
      cur_q    <= raw_i;
      prev_q   <= cur_q;
    end
  end

  assign cur_o    = cur_q;
  assign prev_o   = prev_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/sensirq_cmp.sv
module sensirq_cmp #(
  parameter int W = sensirq_pkg::DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  logic [W-1:0] bit_diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_diff[i] = a_i[i] ^ b_i[i];
  end

  assign diff_o = |bit_diff;
endmodule

// File: rtl/sensirq_pending.sv
module sensirq_pending (
  input  logic clk_i,
  input  logic rst_i,
  input  logic event_i,
  input  logic clear_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        pend_q <= 1'b0;
    else if (event_i) pend_q <= 1'b1;   // a new event wins over a clear
    else if (clear_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sensirq_port.sv
module sensirq_port #(
  parameter int W = sensirq_pkg::DATA_W
) (
  input  logic         cyc_i,
  input  logic         stb_i,
  input  logic [W-1:0] rd_val_i,
  output logic         ack_o,
  output logic [W-1:0] dat_o
);
  logic access;

  assign access = cyc_i & stb_i;
  assign ack_o  = access;
  assign dat_o  = access ? rd_val_i : '0;
endmodule

// File: rtl/sensirq_ctrl.sv
module sensirq_ctrl #(
  parameter int W = sensirq_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cyc_i,
  input  logic         stb_i,
  output logic         ack_o,
  output logic [W-1:0] dat_o,
  input  logic [W-1:0] sense_i,
  output logic         int_req,
  input  logic         int_ack
);
  logic [W-1:0] cur_s;
  logic [W-1:0] prev_s;
  logic         primed;
  logic         chg;

  sensirq_sampler #(.W(W)) u_sampler (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .raw_i    (sense_i),
    .cur_o    (cur_s),
    .prev_o   (prev_s),
    .primed_o (primed)
  );

  sensirq_cmp #(.W(W)) u_cmp (
    .a_i    (cur_s),
    .b_i    (prev_s),
    .diff_o (chg)
  );

  sensirq_pending u_pend (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .event_i (chg),
    .clear_i (int_ack),
    .pend_o  (int_req)
  );

  sensirq_port #(.W(W)) u_port (
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .rd_val_i (cur_s),
    .ack_o    (ack_o),
    .dat_o    (dat_o)
  );
endmodule

// File: rtl/sensirq_chk.sv
module sensirq_chk #(
  parameter int W = sensirq_pkg::DATA_W
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         cyc_i,
  input logic         stb_i,
  input logic         ack_o,
  input logic [W-1:0] dat_o,
  input logic [W-1:0] sense_i,
  input logic         int_req,
  input logic         int_ack,
  input logic         primed,
  input logic [W-1:0] cur_s,
  input logic [W-1:0] prev_s
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) rst_i |=> !int_req);

  // R2
  read_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (primed && cyc_i && stb_i) |-> dat_o == $past(sense_i));

  // R3
  raise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_s != prev_s) |=> int_req);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_req && !int_ack) |=> int_req);

  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_req && int_ack && cur_s == prev_s) |=> !int_req);

  // R7
  quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!int_req && cur_s == prev_s) |=> !int_req);

  // R8
  prime_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !primed |=> !int_req);

  // R9
  ack_chk: assert property (@(posedge clk_i)
    ack_o |-> (cyc_i && stb_i));

  // R9
  idle_data_chk: assert property (@(posedge clk_i)
    !ack_o |-> dat_o == '0);
endmodule

bind sensirq_ctrl sensirq_chk #(.W(W)) i_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .cyc_i   (cyc_i),
  .stb_i   (stb_i),
  .ack_o   (ack_o),
  .dat_o   (dat_o),
  .sense_i (sense_i),
  .int_req (int_req),
  .int_ack (int_ack),
  .primed  (primed),
  .cur_s   (cur_s),
  .prev_s  (prev_s)
);

// File: tb/test_sensirq_ctrl.sv
`timescale 1ns/100ps
module test_sensirq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       cyc_i = 1'b0;
  logic       stb_i = 1'b0;
  logic       ack_o;
  logic [7:0] dat_o;
  logic [7:0] sense_i = 8'h00;
  logic       int_req;
  logic       int_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sensirq_ctrl i_sensirq_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i),
    .ack_o(ack_o), .dat_o(dat_o), .sense_i(sense_i),
    .int_req(int_req), .int_ack(int_ack)
  );

  // {sense, ack, expected int_req}; expected dat_o equals sense
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {8'h3C, 1'b0, 1'b0},  // R3 change sampled, request not yet latched
    {8'h3C, 1'b0, 1'b1},  // R3 request latched
    {8'h3C, 1'b0, 1'b1},  // R4 held
    {8'h3C, 1'b1, 1'b0},  // R5 cleared by ack
    {8'h3C, 1'b0, 1'b0},  // R7 steady
    {8'hA5, 1'b0, 1'b0},
    {8'hA5, 1'b1, 1'b1},  // R6 change and ack together
    {8'hA5, 1'b1, 1'b0},  // R5
    {8'hA4, 1'b0, 1'b0},
    {8'hA4, 1'b0, 1'b1},  // R3 single bit
    {8'hA4, 1'b0, 1'b1},  // R4
    {8'hFF, 1'b1, 1'b0},  // R5
    {8'h00, 1'b0, 1'b1},  // R3
    {8'hFF, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1},  // R6 back-to-back change beats ack
    {8'hFF, 1'b1, 1'b0},  // R5
    {8'hFF, 1'b1, 1'b0}   // R7 ack with nothing pending
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic a);
    @(negedge clk_i);
    sense_i = s;
    int_ack = a;
    @(posedge clk_i);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    // R1: reset state with a nonzero sensor value applied
    cyc_i = 1'b1; stb_i = 1'b1; sense_i = 8'h5A;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 int_req", {7'b0, int_req}, 8'h00);
    check("R1 dat_o", dat_o, 8'h00);

    // R8: release reset with 0x5A present
    @(negedge clk_i); rst_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(8'h5A, 1'b0);
      check("R8 int_req", {7'b0, int_req}, 8'h00);
      check("R2 dat_o", dat_o, 8'h5A);
    end

    // fresh start with zero input for the table
    @(negedge clk_i); rst_i = 1'b1; sense_i = 8'h00;
    @(posedge clk_i);
    @(negedge clk_i); rst_i = 1'b0;
    step(8'h00, 1'b0);
    step(8'h00, 1'b0);
    check("R7 int_req", {7'b0, int_req}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][9:2], VEC[k][1]);
      check($sformatf("R3-table step %0d int_req", k), {7'b0, int_req}, {7'b0, VEC[k][0]});
      check("R2 dat_o", dat_o, VEC[k][9:2]);
      check("R9 ack_o", {7'b0, ack_o}, 8'h01);
    end

    // R9: partial handshakes
    @(negedge clk_i); cyc_i = 1'b1; stb_i = 1'b0; #1;
    check("R9 ack cyc only", {7'b0, ack_o}, 8'h00);
    check("R9 dat idle", dat_o, 8'h00);
    @(negedge clk_i); cyc_i = 1'b0; stb_i = 1'b1; #1;
    check("R9 ack stb only", {7'b0, ack_o}, 8'h00);
    @(negedge clk_i); cyc_i = 1'b1; stb_i = 1'b1;

    // R1: reset while a request is pending
    step(8'h11, 1'b0);
    step(8'h11, 1'b0);
    check("R3 int_req", {7'b0, int_req}, 8'h01);
    @(negedge clk_i); rst_i = 1'b1;
    @(posedge clk_i); #1;
    check("R1 pending cleared", {7'b0, int_req}, 8'h00);
    check("R1 dat cleared", dat_o, 8'h00);
    @(negedge clk_i); rst_i = 1'b0;
    step(8'h11, 1'b0);
    step(8'h11, 1'b0);
    check("R8 after reset", {7'b0, int_req}, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule